// File: doc/BRIEF.md
# Return Frame Format Checker

This block judges the stack frame that is read back while a return-from-exception instruction runs. A start strobe loads the address of the return instruction and the status word in effect at that moment. After that, the frame words come in one at a time, each one marked by a word-valid strobe. The first word is the format/vector word, and its upper nibble is the format code. A code outside the configured legal set is rejected straight away. A code that names the bus-fault frame layout makes the checker count further words until it reaches the word that holds the version field. It then compares that field with a configured constant.

The outcome is a single-cycle pulse. An accept pulse tells the sequencer to go on restoring state. A fault pulse requests a format error exception through vector table entry 14. On a fault, the checker also presents the four-word exception frame to be stacked: the status word, the two halves of the return instruction's own address, and a format/vector word of format 0 with vector offset 0x038.

The state machine has three states: ST_IDLE, ST_FMT (waiting for the format word) and ST_VER (counting bus-fault frame words). The transitions are:
- start moves any state to ST_FMT.
- An illegal code moves ST_FMT to ST_IDLE with a fault.
- A legal code other than the bus-fault code moves ST_FMT to ST_IDLE with an accept.
- The bus-fault code moves ST_FMT to ST_VER.
- The version word moves ST_VER to ST_IDLE, with an accept on a match and a fault otherwise.

Top module: `rte_frame_checker`

## Requirements
- R1: After reset, busy_o, accept_o and fault_o are all low.
- R2: A format word (bits 15:12 = code) whose code is in the legal set (default codes 0x0, 0x1, 0x2, 0xC) and is not the bus-fault code 0xC gives a one-cycle accept_o in the cycle after the word is taken. No fault follows.
- R3: A format word whose code is outside the legal set gives a one-cycle fault_o in the cycle after the word is taken. vec_num_o is 14 and vec_off_o is 0x038.
- R4: When fault_o rises, frm_sr_o holds the status word captured at start, frm_pc_o holds the return instruction address captured at start, and frm_fmtvec_o is 0x0038. These values hold until the next fault.
- R5: After a bus-fault format word (code 0xC), no outcome appears until the 3rd further valid word. That word's bits 15:12 are the version, and a version equal to 0x1 gives accept_o in the cycle after it is taken.
- R6: A bus-fault frame whose version differs from 0x1 gives fault_o, with the frame as in R4.
- R7: Words offered while busy_o is low give no accept_o and no fault_o.
- R8: start_i in any state restarts the check and replaces the captured address and status word. busy_o is high in the following cycle.
- R9: Each frame gives exactly one outcome. accept_o and fault_o are never high together, each lasts one cycle, and busy_o is low once the outcome appears.
- R10: Cycles with word_valid_i low do not advance the frame word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin checking a new frame |
| rte_pc_i | input | 32 | Address of the return instruction, captured at start |
| sr_i | input | 16 | Status word, captured at start |
| word_valid_i | input | 1 | word_i carries a popped frame word |
| word_i | input | 16 | Popped frame word |
| busy_o | output | 1 | A frame check is in progress |
| accept_o | output | 1 | One-cycle pulse: frame is acceptable |
| fault_o | output | 1 | One-cycle pulse: format error exception request |
| vec_num_o | output | 8 | Exception vector number (14) |
| vec_off_o | output | 10 | Vector offset, vector number times 4 |
| frm_sr_o | output | 16 | Frame word: saved status word |
| frm_pc_o | output | 32 | Frame words: address of the return instruction |
| frm_fmtvec_o | output | 16 | Frame word: format 0 and vector offset |

## Verification
A wrong state or a wrong word count shows up at the ports within one word, as an outcome pulse at the wrong position. It can also show up as an outcome that never comes, which leaves busy_o high, or as a second pulse. The bench records the word position at which the single outcome appears in each frame, and compares it and its kind with the expectation. A stale capture register shows up in frm_pc_o or frm_sr_o on the very next fault. The restart case targets this by interrupting a bus-fault frame part way through.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FMT  = 2'd1,
        ST_VER  = 2'd2
    } rfc_state_e;

    localparam int FMT_CODE_W = 4;
    localparam int VOFF_W     = 12;

    function automatic logic [15:0] make_fmtvec(input logic [3:0] fmt, input logic [11:0] voff);
        return {fmt, voff};
    endfunction

endpackage

// File: rtl/rfc_fmt_decode.sv
module rfc_fmt_decode #(
    parameter logic [15:0] LEGAL_MASK = 16'h1007,
    parameter logic [3:0]  BUSFLT_FMT = 4'hC
) (
    input  logic [3:0] code_i,
    output logic       legal_o,
    output logic       is_bus_o
);
    always_comb begin
        legal_o  = LEGAL_MASK[code_i];
        is_bus_o = legal_o && (code_i == BUSFLT_FMT);
    end
endmodule

// File: rtl/rfc_word_counter.sv
module rfc_word_counter #(
    parameter int LAST = 3,
    localparam int CW  = (LAST < 2) ? 1 : $clog2(LAST + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    localparam logic [CW-1:0] LAST_M1 = CW'(LAST - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = inc_i && (cnt_q == LAST_M1);
endmodule

// File: rtl/rfc_frame_builder.sv
module rfc_frame_builder #(
    parameter logic [11:0] VEC_OFF = 12'h038
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [31:0] pc_i,
    input  logic [15:0] sr_i,
    output logic [15:0] frm_sr_o,
    output logic [31:0] frm_pc_o,
    output logic [15:0] frm_fmtvec_o
);
    import rfc_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_sr_o     <= '0;
            frm_pc_o     <= '0;
            frm_fmtvec_o <= '0;
        end else if (load_i) begin
            frm_sr_o     <= sr_i;
            frm_pc_o     <= pc_i;
            frm_fmtvec_o <= make_fmtvec(4'h0, VEC_OFF);
        end
    end
endmodule

// File: rtl/rte_frame_checker.sv
module rte_frame_checker #(
    parameter logic [15:0] LEGAL_MASK = 16'h1007,
    parameter logic [3:0]  BUSFLT_FMT = 4'hC,
    parameter int          VER_IDX    = 3,
    parameter int          VER_LSB    = 12,
    parameter int          VER_W      = 4,
    parameter logic [VER_W-1:0] VER_EXP = 1,
    parameter int          FMTERR_VEC = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] rte_pc_i,
    input  logic [15:0] sr_i,
    input  logic        word_valid_i,
    input  logic [15:0] word_i,
    output logic        busy_o,
    output logic        accept_o,
    output logic        fault_o,
    output logic [7:0]  vec_num_o,
    output logic [9:0]  vec_off_o,
    output logic [15:0] frm_sr_o,
    output logic [31:0] frm_pc_o,
    output logic [15:0] frm_fmtvec_o
);
    import rfc_pkg::*;

    localparam logic [7:0]  VEC_NUM  = 8'(FMTERR_VEC);
    localparam logic [9:0]  VEC_OFFS = 10'(FMTERR_VEC * 4);
    localparam logic [11:0] VEC_OFFW = 12'(FMTERR_VEC * 4);

    rfc_state_e state_q, state_d;
    logic [31:0] pc_q;
    logic [15:0] sr_q;
    logic        acc_d, flt_d, cnt_clr, cnt_inc, cnt_hit;
    logic        code_legal, code_bus, ver_ok;

    rfc_fmt_decode #(.LEGAL_MASK(LEGAL_MASK), .BUSFLT_FMT(BUSFLT_FMT)) u_dec (
        .code_i   (word_i[15:12]),
        .legal_o  (code_legal),
        .is_bus_o (code_bus)
    );

    rfc_word_counter #(.LAST(VER_IDX)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .hit_o (cnt_hit)
    );

    rfc_frame_builder #(.VEC_OFF(VEC_OFFW)) u_frm (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (flt_d),
        .pc_i         (pc_q),
        .sr_i         (sr_q),
        .frm_sr_o     (frm_sr_o),
        .frm_pc_o     (frm_pc_o),
        .frm_fmtvec_o (frm_fmtvec_o)
    );

    assign ver_ok = (word_i[VER_LSB +: VER_W] == VER_EXP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            sr_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                pc_q <= rte_pc_i;
                sr_q <= sr_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        acc_d   = 1'b0;
        flt_d   = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (start_i) begin
            state_d = ST_FMT;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_FMT: begin
                    if (word_valid_i) begin
                        if (!code_legal) begin
                            flt_d   = 1'b1;
                            state_d = ST_IDLE;
                        end else if (code_bus) begin
                            cnt_clr = 1'b1;
                            state_d = ST_VER;
                        end else begin
                            acc_d   = 1'b1;
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_VER: begin
                    cnt_inc = word_valid_i;
                    if (cnt_hit) begin
                        acc_d   = ver_ok;
                        flt_d   = !ver_ok;
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_o <= 1'b0;
            fault_o  <= 1'b0;
        end else begin
            accept_o <= acc_d;
            fault_o  <= flt_d;
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign vec_num_o = VEC_NUM;
    assign vec_off_o = VEC_OFFS;

endmodule

// File: rtl/rte_frame_checker_chk.sv
module rte_frame_checker_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic accept_o,
    input logic fault_o
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && fault_o)); // R9
    AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o); // R9
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o); // R9
    AST_OUTCOME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o || fault_o) |-> !busy_o); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !(accept_o || fault_o)); // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !accept_o && !fault_o)); // R8
endmodule

bind rte_frame_checker rte_frame_checker_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .accept_o (accept_o),
    .fault_o  (fault_o)
);

// File: tb/rte_frame_checker_tb.sv
module rte_frame_checker_tb;
    localparam time CLK_P = 20ns;
    localparam logic [15:0] LEGAL = 16'h1007;
    localparam logic [3:0]  BUSC  = 4'hC;
    localparam int          VIDX  = 3;
    localparam logic [3:0]  VEXP  = 4'h1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, word_valid_i = 1'b0;
    logic [31:0] rte_pc_i = '0;
    logic [15:0] sr_i = '0, word_i = '0;
    logic busy_o, accept_o, fault_o;
    logic [7:0] vec_num_o;
    logic [9:0] vec_off_o;
    logic [15:0] frm_sr_o, frm_fmtvec_o;
    logic [31:0] frm_pc_o;

    int n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    rte_frame_checker u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_accept(input logic [3:0] code, input logic [3:0] ver);
        if (!LEGAL[code]) return 1'b0;
        if (code == BUSC) return ver == VEXP;
        return 1'b1;
    endfunction

    function automatic int exp_len(input logic [3:0] code);
        return (LEGAL[code] && code == BUSC) ? 1 + VIDX : 1;
    endfunction

    task automatic run_frame(input logic [31:0] pc, input logic [15:0] sr, input logic [3:0] code,
                             input logic [3:0] ver, input bit gaps, input string req);
        int n, seen_at, hits, pos;
        bit acc, seen_acc;
        n = exp_len(code);
        acc = exp_accept(code, ver);
        seen_at = 0; hits = 0; pos = 0; seen_acc = 0;
        @(negedge clk);
        start_i = 1'b1; rte_pc_i = pc; sr_i = sr;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R8", busy_o, 1);
        for (int i = 0; i < n; i++) begin
            if (gaps && $urandom_range(1, 0) == 1) begin
                word_valid_i = 1'b0;
                word_i = 16'($urandom);
                @(negedge clk);
                if (accept_o || fault_o) begin hits++; seen_at = -1; end
            end
            word_valid_i = 1'b1;
            if (i == 0)         word_i = {code, 12'($urandom)};
            else if (i == VIDX) word_i = {ver, 12'($urandom)};
            else                word_i = 16'($urandom);
            pos++;
            @(negedge clk);
            word_valid_i = 1'b0;
            if (accept_o || fault_o) begin hits++; seen_at = pos; seen_acc = accept_o; end
        end
        chk(hits == 1 && seen_at == n, {req, " outcome position"}, 32'(seen_at), 32'(n));
        chk(seen_acc == acc, {req, " outcome kind"}, 32'(seen_acc), 32'(acc));
        chk(busy_o == 1'b0, "R9 busy after outcome", busy_o, 0);
        if (!acc) begin
            chk(frm_pc_o == pc, "R4 frame pc", frm_pc_o, pc);
            chk(frm_sr_o == sr, "R4 frame sr", 32'(frm_sr_o), 32'(sr));
            chk(frm_fmtvec_o == 16'h0038, "R4 fmtvec", 32'(frm_fmtvec_o), 32'h38);
            chk(vec_num_o == 8'd14 && vec_off_o == 10'h038, "R3 vector", {vec_num_o, 14'd0, vec_off_o}, 32'h0e000038);
        end
        @(negedge clk);
        chk(!accept_o && !fault_o, "R9 single-cycle pulse", {accept_o, fault_o}, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk({busy_o, accept_o, fault_o} === 3'b000, "R1 reset", {busy_o, accept_o, fault_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, accept_o, fault_o} === 3'b000, "R1 after release", {busy_o, accept_o, fault_o}, 0);

        run_frame(32'h0000_1000, 16'h2700, 4'h0, 4'h0, 0, "R2 code0");
        run_frame(32'h0000_2002, 16'h2000, 4'h2, 4'h0, 0, "R2 code2");
        run_frame(32'h0000_3004, 16'h2704, 4'h3, 4'h0, 0, "R3 code3");
        run_frame(32'hFFFF_FFFE, 16'hA71F, 4'hF, 4'h0, 0, "R3 codeF");
        run_frame(32'h0040_0010, 16'h2300, BUSC, VEXP, 0, "R5 bus ok");
        run_frame(32'h0040_0020, 16'h2301, BUSC, 4'h7, 0, "R6 bus badver");
        run_frame(32'h0040_0030, 16'h2302, BUSC, VEXP, 1, "R10 bus gaps");
        run_frame(32'h0040_0040, 16'h2303, BUSC, 4'h0, 1, "R10 bus gaps badver");

        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            word_valid_i = 1'b1; word_i = 16'h5000;
            @(negedge clk);
            word_valid_i = 1'b0;
            chk(!accept_o && !fault_o && !busy_o, "R7 idle word ignored", {busy_o, accept_o, fault_o}, 0);
        end

        @(negedge clk);
        start_i = 1'b1; rte_pc_i = 32'hDEAD_0000; sr_i = 16'h1111;
        @(negedge clk);
        start_i = 1'b0; word_valid_i = 1'b1; word_i = {BUSC, 12'h000};
        @(negedge clk);
        word_i = 16'h0;
        @(negedge clk);
        word_valid_i = 1'b0;
        chk(!accept_o && !fault_o && busy_o, "R8 mid-frame", {busy_o, accept_o, fault_o}, 3'b100);
        run_frame(32'h0000_BEEF, 16'h2222, 4'h9, 4'h0, 0, "R8 restart");

        for (int r = 0; r < 40; r++) begin
            logic [3:0] c, v;
            c = ($urandom_range(2, 0) == 0) ? BUSC : 4'($urandom);
            v = ($urandom_range(1, 0) == 0) ? VEXP : 4'($urandom);
            run_frame($urandom, 16'($urandom), c, v, 1'($urandom), "R9 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule